// File: doc/BRIEF.md
# Crystal Frequency Window Monitor

This block watches an external crystal clock using a trusted internal reference clock. Over a fixed window of 1024 reference cycles, the crystal domain keeps a free-running edge counter. The reference domain samples that counter at each window boundary. The difference between two successive samples is the number of crystal edges in the window. The block clamps that count to ten bits and compares it with a programmable pair of limits. A count outside the limits latches a sticky frequency fault. A separate watchdog latches a sticky stop fault when the crystal stops toggling.

Software, or a higher-level clock controller, does three things with the block. It enables each detector on its own. It picks which faults raise the shared interrupt. It clears each fault by pulsing that fault's write-1-to-clear input. All control inputs, outputs and flags live in the reference domain. Only the Gray-coded edge counter crosses between the two clocks.

Top module: `xtal_freq_monitor`

## Requirements
- R1: While the frequency monitor is enabled, each measurement window spans exactly 1024 reference edges. For an out-of-range crystal, the frequency fault becomes visible just after the 2049th reference edge that samples the enable high.
- R2: A window count strictly greater than the upper limit sets the frequency fault.
- R3: A window count strictly less than the lower limit sets the frequency fault.
- R4: A window count within the limits (inclusive) leaves the frequency fault clear.
- R5: The window count saturates at 1023. A crystal far faster than the reference never sets the fault when the upper limit is 1023, and always sets it when the upper limit is 1022.
- R6: The first window after the enable rises is never compared, so no fault can appear before the second window ends.
- R7: With the stop detector enabled, 64 consecutive reference cycles without a crystal edge set the stop fault. A running crystal never sets it.
- R8: A one-cycle pulse on a clear input clears its fault on the next reference edge. The stop fault is not set again while the crystal stays stopped.
- R9: Neither fault can be set while its detector enable is low.
- R10: The interrupt is high exactly when some fault is set and that fault's interrupt enable is high.
- R11: The crystal-domain counter changes by at most one bit per crystal edge, so every sample taken in the reference domain is a valid count.
- R12: After reset both faults and the interrupt are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Trusted internal reference clock; all control and flags use it |
| xtal_clk | input | 1 | Crystal clock under test |
| rst_n | input | 1 | Synchronous active-low reset (re-synchronized into the crystal domain) |
| fmon_en | input | 1 | Frequency window monitor enable |
| fmon_irq_en | input | 1 | Interrupt enable for the frequency fault |
| stop_en | input | 1 | Stop detector enable |
| stop_irq_en | input | 1 | Interrupt enable for the stop fault |
| upper_lim | input | 10 | Highest crystal edge count per window that is still accepted |
| lower_lim | input | 10 | Lowest crystal edge count per window that is still accepted |
| freq_clr | input | 1 | Write-1-to-clear pulse for the frequency fault |
| stop_clr | input | 1 | Write-1-to-clear pulse for the stop fault |
| freq_fault | output | 1 | Sticky frequency-out-of-window fault |
| stop_fault | output | 1 | Sticky crystal-stopped fault |
| irq | output | 1 | Combined interrupt |

## Verification
The frequency fault is due on the 2049th reference edge after the enable is sampled high. The bench therefore samples at edge 2040, where the fault must still be low, and again at edge 2060, where it must be high. This bracket absorbs the crystal-edge uncertainty of one or two counts that comes from the synchronizer. The stop fault appears about 67 reference edges after the last crystal edge: 64 quiet cycles plus the synchronizer stages. The bench samples it 40 cycles after stopping, expecting low, and 100 cycles after, expecting high. Clear pulses take effect on the next edge. The interrupt is combinational and is sampled after each input change settles. All samples fall 2 time units after a reference rising edge.

// File: rtl/fmon_pkg.sv
// Package: shared constants and types for the crystal frequency window monitor.
// Assumes: the reference clock is the trusted timebase; every width derives from these.
package fmon_pkg;

    localparam int unsigned FM_LIM_W      = 10;    // width of the window limits
    localparam int unsigned FM_CNT_W      = 14;    // crystal edge counter width (wrap margin)
    localparam int unsigned FM_WIN_CYCLES = 1024;  // reference cycles per window
    localparam int unsigned FM_STOP_QUIET = 64;    // quiet reference cycles meaning "stopped"
    localparam int unsigned FM_SYNC_STAGES = 2;    // synchronizer depth into the reference domain

    // Window sequencer state: off, first (discarded) window, measuring
    typedef enum logic [1:0] {
        WS_OFF   = 2'd0,
        WS_PRIME = 2'd1,
        WS_RUN   = 2'd2
    } win_state_e;

endpackage

// File: rtl/fmon_xtal_counter.sv
// Module: free-running crystal-domain edge counter published in Gray code.
// Assumes: rst_n comes from the reference domain; it is re-timed here through
// SYNC_STAGES flops so that release is clean in the crystal domain.
module fmon_xtal_counter #(
    parameter int unsigned CNT_W       = 14,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             xtal_clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] gray_o
);

    logic [SYNC_STAGES-1:0] rst_pipe;
    logic                   local_rst_n;
    logic [CNT_W-1:0]       bin_q;
    logic [CNT_W-1:0]       bin_next;
    logic [CNT_W-1:0]       gray_q;

    // Re-time the reset release into the crystal domain
    always_ff @(posedge xtal_clk) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end

    assign local_rst_n = rst_pipe[SYNC_STAGES-1];
    assign bin_next    = bin_q + 1'b1;

    // Count every crystal edge and register its Gray image for the crossing
    always_ff @(posedge xtal_clk) begin
        if (!local_rst_n) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else begin
            bin_q  <= bin_next;
            gray_q <= bin_next ^ (bin_next >> 1);
        end
    end

    assign gray_o = gray_q;

    // R11: the crossing word moves by at most one bit per crystal edge
    p_gray_one_bit_r11: assert property (@(posedge xtal_clk) disable iff (!local_rst_n)
        $countones(gray_q ^ $past(gray_q)) <= 1);

endmodule

// File: rtl/fmon_gray_sync.sv
// Module: brings the Gray count into the reference domain and decodes it.
// Assumes: the input changes at most one bit per crystal edge, so any sample is valid.
module fmon_gray_sync #(
    parameter int unsigned CNT_W       = 14,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] gray_i,
    output logic [CNT_W-1:0] gray_o,
    output logic [CNT_W-1:0] bin_o
);

    logic [SYNC_STAGES-1:0][CNT_W-1:0] sync_q;

    // Shift the Gray word through the synchronizer chain
    always_ff @(posedge ref_clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], gray_i};
    end

    assign gray_o = sync_q[SYNC_STAGES-1];

    // Decode Gray to binary, most significant bit first
    always_comb begin
        bin_o[CNT_W-1] = gray_o[CNT_W-1];
        for (int i = int'(CNT_W) - 2; i >= 0; i--) begin
            bin_o[i] = bin_o[i+1] ^ gray_o[i];
        end
    end

endmodule

// File: rtl/fmon_window.sv
// Module: reference-domain window sequencer, edge-count difference and limit compare.
// Assumes: cnt_bin_i is the synchronized crystal count; fewer than 2**CNT_W crystal
// edges occur per window, so the modulo difference is exact.
module fmon_window
    import fmon_pkg::*;
#(
    parameter int unsigned CNT_W      = 14,
    parameter int unsigned LIM_W      = 10,
    parameter int unsigned WIN_CYCLES = 1024
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] cnt_bin_i,
    input  logic [LIM_W-1:0] upper_i,
    input  logic [LIM_W-1:0] lower_i,
    output logic             fault_o
);

    localparam int unsigned WIN_W   = $clog2(WIN_CYCLES);
    localparam int unsigned SAT_MAX = (1 << LIM_W) - 1;

    win_state_e       state;
    logic [WIN_W-1:0] win_cnt;
    logic             win_end;
    logic [CNT_W-1:0] prev_cnt;
    logic [CNT_W-1:0] diff_q;
    logic             eval_q;
    logic [LIM_W-1:0] sat_cnt;

    assign win_end = (win_cnt == WIN_W'(WIN_CYCLES - 1));

    // Sequence windows; the first one only seeds the reference sample
    always_ff @(posedge ref_clk) begin
        if (!rst_n || !enable) begin
            state    <= WS_OFF;
            win_cnt  <= '0;
            prev_cnt <= '0;
            diff_q   <= '0;
            eval_q   <= 1'b0;
        end else begin
            eval_q <= 1'b0;
            if (win_end) begin
                win_cnt  <= '0;
                prev_cnt <= cnt_bin_i;
                if (state == WS_RUN) begin
                    diff_q <= cnt_bin_i - prev_cnt;
                    eval_q <= 1'b1;
                end
                state <= WS_RUN;
            end else begin
                win_cnt <= win_cnt + 1'b1;
                if (state == WS_OFF) state <= WS_PRIME;
            end
        end
    end

    // Clamp the window count to the limit width
    always_comb begin
        if (diff_q > CNT_W'(SAT_MAX)) sat_cnt = '1;
        else                          sat_cnt = diff_q[LIM_W-1:0];
    end

    assign fault_o = enable && eval_q && ((sat_cnt > upper_i) || (sat_cnt < lower_i));

    // R6: a compare only follows a window that began in the measuring state
    p_first_discard_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        eval_q |-> ($past(state) == WS_RUN));

    // R1: compares are single-cycle events, one per window
    p_one_eval_r1: assert property (@(posedge ref_clk) disable iff (!rst_n)
        eval_q |=> !eval_q);

    // R1: the window counter restarts after its last cycle
    p_win_wrap_r1: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (enable && win_end) |=> (win_cnt == '0));

endmodule

// File: rtl/fmon_stop_det.sv
// Module: declares a stop when the synchronized crystal count stays frozen.
// Assumes: the reference clock keeps running; a pulse is emitted once per stop episode.
module fmon_stop_det #(
    parameter int unsigned CNT_W       = 14,
    parameter int unsigned STOP_QUIET  = 64
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] gray_i,
    output logic             stop_o
);

    localparam int unsigned IDLE_W = $clog2(STOP_QUIET + 1);

    logic [CNT_W-1:0]  prev_gray;
    logic [IDLE_W-1:0] idle_cnt;
    logic              moved;

    assign moved = (gray_i != prev_gray);

    // Track the last sample and count consecutive cycles without movement
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            prev_gray <= '0;
            idle_cnt  <= '0;
        end else begin
            prev_gray <= gray_i;
            if (!enable || moved)                        idle_cnt <= '0;
            else if (idle_cnt != IDLE_W'(STOP_QUIET))    idle_cnt <= idle_cnt + 1'b1;
        end
    end

    assign stop_o = enable && !moved && (idle_cnt == IDLE_W'(STOP_QUIET - 1));

    // R7: one stop event per quiet episode
    p_stop_once_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
        stop_o |=> !stop_o);

    // R7: a stop is only declared while the crossing word is frozen
    p_stop_quiet_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
        stop_o |-> $stable(gray_i));

endmodule

// File: rtl/xtal_freq_monitor.sv
// Module: top of the crystal frequency window monitor; holds the sticky faults and interrupt.
// Assumes: all controls are in the reference domain; rst_n is held while both clocks run.
module xtal_freq_monitor
    import fmon_pkg::*;
#(
    parameter int unsigned LIM_W       = FM_LIM_W,
    parameter int unsigned CNT_W       = FM_CNT_W,
    parameter int unsigned WIN_CYCLES  = FM_WIN_CYCLES,
    parameter int unsigned STOP_QUIET  = FM_STOP_QUIET,
    parameter int unsigned SYNC_STAGES = FM_SYNC_STAGES
) (
    input  logic             ref_clk,
    input  logic             xtal_clk,
    input  logic             rst_n,
    input  logic             fmon_en,
    input  logic             fmon_irq_en,
    input  logic             stop_en,
    input  logic             stop_irq_en,
    input  logic [LIM_W-1:0] upper_lim,
    input  logic [LIM_W-1:0] lower_lim,
    input  logic             freq_clr,
    input  logic             stop_clr,
    output logic             freq_fault,
    output logic             stop_fault,
    output logic             irq
);

    logic [CNT_W-1:0] xtal_gray;
    logic [CNT_W-1:0] ref_gray;
    logic [CNT_W-1:0] ref_bin;
    logic             win_fault;
    logic             stop_evt;

    fmon_xtal_counter #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_xcnt (
        .xtal_clk (xtal_clk),
        .rst_n    (rst_n),
        .gray_o   (xtal_gray)
    );

    fmon_gray_sync #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .gray_i  (xtal_gray),
        .gray_o  (ref_gray),
        .bin_o   (ref_bin)
    );

    fmon_window #(.CNT_W(CNT_W), .LIM_W(LIM_W), .WIN_CYCLES(WIN_CYCLES)) u_win (
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .enable    (fmon_en),
        .cnt_bin_i (ref_bin),
        .upper_i   (upper_lim),
        .lower_i   (lower_lim),
        .fault_o   (win_fault)
    );

    fmon_stop_det #(.CNT_W(CNT_W), .STOP_QUIET(STOP_QUIET)) u_stop (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .enable  (stop_en),
        .gray_i  (ref_gray),
        .stop_o  (stop_evt)
    );

    // Sticky frequency fault: a new fault wins over a simultaneous clear
    always_ff @(posedge ref_clk) begin
        if (!rst_n)         freq_fault <= 1'b0;
        else if (win_fault) freq_fault <= 1'b1;
        else if (freq_clr)  freq_fault <= 1'b0;
    end

    // Sticky stop fault: a new stop wins over a simultaneous clear
    always_ff @(posedge ref_clk) begin
        if (!rst_n)        stop_fault <= 1'b0;
        else if (stop_evt) stop_fault <= 1'b1;
        else if (stop_clr) stop_fault <= 1'b0;
    end

    assign irq = (freq_fault && fmon_irq_en) || (stop_fault && stop_irq_en);

    // R9: the frequency fault rises only with its detector enabled
    p_freq_needs_en_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(freq_fault) |-> $past(fmon_en));

    // R9: the stop fault rises only with its detector enabled
    p_stop_needs_en_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(stop_fault) |-> $past(stop_en));

    // R8: a clear with the detector idle always leaves the fault low
    p_freq_clear_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (freq_clr && !fmon_en) |=> !freq_fault);

    // R8: same for the stop fault
    p_stop_clear_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (stop_clr && !stop_en) |=> !stop_fault);

endmodule

// File: tb/xtal_freq_monitor_bench.sv
// Bench: directed scenarios for the crystal frequency window monitor.
module xtal_freq_monitor_bench;

    localparam int REF_PERIOD = 10;
    localparam int REF_HALF   = REF_PERIOD / 2;

    logic       ref_clk  = 1'b0;
    logic       xtal_clk = 1'b0;
    logic       rst_n    = 1'b0;
    logic       fmon_en, fmon_irq_en, stop_en, stop_irq_en;
    logic [9:0] upper_lim, lower_lim;
    logic       freq_clr, stop_clr;
    logic       freq_fault, stop_fault, irq;

    int xtal_half = 10;
    bit xtal_run  = 1'b1;
    int n_checks  = 0;
    int n_fails   = 0;

    xtal_freq_monitor u_xtal_freq_monitor (
        .ref_clk     (ref_clk),
        .xtal_clk    (xtal_clk),
        .rst_n       (rst_n),
        .fmon_en     (fmon_en),
        .fmon_irq_en (fmon_irq_en),
        .stop_en     (stop_en),
        .stop_irq_en (stop_irq_en),
        .upper_lim   (upper_lim),
        .lower_lim   (lower_lim),
        .freq_clr    (freq_clr),
        .stop_clr    (stop_clr),
        .freq_fault  (freq_fault),
        .stop_fault  (stop_fault),
        .irq         (irq)
    );

    always #(REF_HALF) ref_clk = ~ref_clk;

    always begin
        #(xtal_half);
        if (xtal_run) xtal_clk = ~xtal_clk;
    end

    task automatic check_eq(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_ref(input int n);
        repeat (n) @(posedge ref_clk);
        #2;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        fmon_en = 0; fmon_irq_en = 0; stop_en = 0; stop_irq_en = 0;
        upper_lim = 10'd0; lower_lim = 10'd0;
        freq_clr = 0; stop_clr = 0;
        xtal_run = 1'b1;
        wait_ref(8);
        rst_n = 1'b1;
        wait_ref(4);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    // R12: reset state
    task automatic t_reset();
        do_reset();
        check_eq("R12 freq_fault after reset", freq_fault, 0);
        check_eq("R12 stop_fault after reset", stop_fault, 0);
        check_eq("R12 irq after reset", irq, 0);
    endtask

    // R4/R11: ~512 edges per window inside 480..540
    task automatic t_in_range();
        do_reset();
        xtal_half = 10; lower_lim = 10'd480; upper_lim = 10'd540;
        fmon_en = 1;
        wait_ref(2060);
        check_eq("R4 R11 in-range window, no fault", freq_fault, 0);
        wait_ref(1024);
        check_eq("R4 in-range third window, no fault", freq_fault, 0);
    endtask

    // R1/R2/R6: ~853 edges per window above 540; fault only after second window
    task automatic t_above();
        do_reset();
        xtal_half = 6; lower_lim = 10'd480; upper_lim = 10'd540;
        fmon_en = 1;
        wait_ref(2040);
        check_eq("R6 R1 first window discarded, fault still low", freq_fault, 0);
        wait_ref(20);
        check_eq("R2 R1 count above upper sets fault", freq_fault, 1);
        freq_clr = 1;
        wait_ref(1);
        freq_clr = 0;
        check_eq("R8 clear pulse drops frequency fault", freq_fault, 0);
        wait_ref(5);
        check_eq("R8 frequency fault stays clear", freq_fault, 0);
    endtask

    // R3: ~256 edges per window below 480
    task automatic t_below();
        do_reset();
        xtal_half = 20; lower_lim = 10'd480; upper_lim = 10'd540;
        fmon_en = 1;
        wait_ref(2060);
        check_eq("R3 count below lower sets fault", freq_fault, 1);
    endtask

    // R5: ~5120 edges per window clamp to 1023
    task automatic t_saturate();
        do_reset();
        xtal_half = 1; lower_lim = 10'd0; upper_lim = 10'd1023;
        fmon_en = 1;
        wait_ref(3100);
        check_eq("R5 saturated count not above 1023", freq_fault, 0);
        do_reset();
        xtal_half = 1; lower_lim = 10'd0; upper_lim = 10'd1022;
        fmon_en = 1;
        wait_ref(2060);
        check_eq("R5 saturated count above 1022", freq_fault, 1);
        xtal_half = 10;
    endtask

    // R9: detectors disabled see an out-of-range then stopped crystal
    task automatic t_disabled();
        do_reset();
        xtal_half = 6; lower_lim = 10'd480; upper_lim = 10'd540;
        fmon_irq_en = 1; stop_irq_en = 1;
        wait_ref(2100);
        xtal_run = 1'b0;
        wait_ref(200);
        check_eq("R9 disabled monitor leaves frequency fault low", freq_fault, 0);
        check_eq("R9 disabled stop detector leaves stop fault low", stop_fault, 0);
        check_eq("R9 irq low with detectors disabled", irq, 0);
        xtal_run = 1'b1;
        xtal_half = 10;
    endtask

    // R7/R8: stop detection, clear while stopped, second episode
    task automatic t_stop();
        do_reset();
        xtal_half = 10;
        stop_en = 1;
        wait_ref(100);
        check_eq("R7 running crystal gives no stop fault", stop_fault, 0);
        xtal_run = 1'b0;
        wait_ref(40);
        check_eq("R7 no stop fault before 64 quiet cycles", stop_fault, 0);
        wait_ref(60);
        check_eq("R7 stop fault after 64 quiet cycles", stop_fault, 1);
        stop_clr = 1;
        wait_ref(1);
        stop_clr = 0;
        check_eq("R8 clear pulse drops stop fault", stop_fault, 0);
        wait_ref(100);
        check_eq("R8 stop fault not re-set while still stopped", stop_fault, 0);
        xtal_run = 1'b1;
        wait_ref(30);
        check_eq("R7 restarted crystal keeps stop fault low", stop_fault, 0);
        xtal_run = 1'b0;
        wait_ref(100);
        check_eq("R7 second stop episode sets fault", stop_fault, 1);
        xtal_run = 1'b1;
    endtask

    // R10: interrupt gating by each enable
    task automatic t_irq();
        do_reset();
        xtal_half = 6; lower_lim = 10'd480; upper_lim = 10'd540;
        fmon_en = 1;
        wait_ref(2060);
        check_eq("R10 fault set, irq masked", irq, 0);
        fmon_irq_en = 1;
        #1;
        check_eq("R10 fault set, irq enabled", irq, 1);
        fmon_irq_en = 0;
        stop_irq_en = 1;
        #1;
        check_eq("R10 stop irq enable alone does not pass frequency fault", irq, 0);
        stop_en = 1;
        xtal_run = 1'b0;
        wait_ref(100);
        check_eq("R10 stop fault with its enable raises irq", irq, 1);
        xtal_run = 1'b1;
        xtal_half = 10;
    endtask

    initial begin
        t_reset();
        t_in_range();
        t_above();
        t_below();
        t_saturate();
        t_disabled();
        t_stop();
        t_irq();
        summary();
        $finish;
    end

    initial begin
        #(REF_PERIOD * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

endmodule